// File: doc/BRIEF.md
# Instruction Trace Breakpoint Filter

This block sits beside one processor core inside the gated clock domain of a simulated multicore. Every retired instruction gives one trace packet, holding the program counter, an exception code and a result word. A debug controller selects how the packets are treated. They can all be discarded so that the core runs freely. They can all be passed on, which supports cycle-stepping and verification. Or the filter can wait for a breakpoint, which is either a given instruction address or a given exception code.

When a breakpoint hits, the packet that caused it goes to the debug side over a valid/ready channel. In the same cycle the filter raises a one-cycle pause request. That request stops the clock of the whole simulated system, not only the core, so no internal latency is hidden. The controller reprograms the filter only while the domain is paused. The first packet after a hit is exempt from matching, so resuming past a breakpoint does not trigger it again at once.

Top module: `trace_bp_filter`

## Requirements
- R1: After reset the output is not valid, the pause request is low, the input is ready, the mode is pass-all (code 1) and the match value is zero.
- R2: In drop mode (mode code 0) every accepted packet is discarded, the input stays ready and no pause request is raised.
- R3: In pass mode (mode code 1) every accepted packet is forwarded unchanged and in order, and no pause request is raised.
- R4: In address mode (mode code 2) a packet is forwarded only when its program counter equals the match value. Every other packet is discarded.
- R5: In exception mode (mode code 3) a packet is forwarded only when its exception code equals the low 5 bits of the match value. Every other packet is discarded.
- R6: The pause request is high for exactly the cycle in which a matching packet is accepted, and at no other time. It is never high in two consecutive cycles.
- R7: In address or exception mode, the first packet accepted after a matching packet is discarded even if it would match. The packet after that is matched normally.
- R8: A configuration write updates the mode (select 0, low 2 bits of the write data) or the match value (select 1). It takes effect from the next cycle, and only if the pause input is high when the write is made. A write made while the pause input is low has no effect.
- R9: While the output is valid and output ready is low, the output fields stay unchanged and input ready is low. No packet is lost.
- R10: A forwarded packet appears at the output in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock of the gated domain |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Trace packet valid |
| in_ready_o | output | 1 | Filter can take a packet |
| in_pc_i | input | ADDR_W | Packet program counter |
| in_exc_i | input | EXC_W | Packet exception code |
| in_res_i | input | RES_W | Packet result word |
| out_valid_o | output | 1 | Forwarded packet valid |
| out_ready_i | input | 1 | Debug side can take a packet |
| out_pc_o | output | ADDR_W | Forwarded program counter |
| out_exc_o | output | EXC_W | Forwarded exception code |
| out_res_o | output | RES_W | Forwarded result word |
| paused_i | input | 1 | Simulated domain is paused |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 writes the mode, 1 writes the match value |
| cfg_wdata_i | input | MATCH_W | Configuration write data |
| pause_req_o | output | 1 | One-cycle request to stop the domain clock |

## Verification
The hardest case to reach is a matching packet that arrives right after an earlier hit, while the forwarded packet is still held by output backpressure. Here the exemption after a hit, the stall and the pause pulse all act at once. The stimulus builds this on purpose: it programs an address breakpoint and sends the same program counter several times in a row with output ready low. It also issues configuration writes both while paused and while running. A seeded random phase then draws program counters and exception codes from small sets, so that hits, repeated hits and mode changes in mid-stream happen often.

// File: rtl/trace_bp_pkg.sv
package trace_bp_pkg;
  typedef enum logic [1:0] {
    BP_DROP = 2'd0,
    BP_PASS = 2'd1,
    BP_ADDR = 2'd2,
    BP_EXC  = 2'd3
  } bp_mode_e;

  localparam logic CFG_SEL_MODE  = 1'b0;
  localparam logic CFG_SEL_MATCH = 1'b1;
endpackage

// File: rtl/trace_bp_cfg.sv
module trace_bp_cfg
  import trace_bp_pkg::*;
#(
  parameter int MATCH_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               paused_i,
  input  logic               we_i,
  input  logic               sel_i,
  input  logic [MATCH_W-1:0] wdata_i,
  output bp_mode_e           mode_o,
  output logic [MATCH_W-1:0] match_o
);
  bp_mode_e           mode_q;
  logic [MATCH_W-1:0] match_q;
  logic               wr_ok;

  // writes only land while the domain clock is stopped
  assign wr_ok = we_i && paused_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= BP_PASS;
      match_q <= '0;
    end else if (wr_ok) begin
      if (sel_i == CFG_SEL_MODE) mode_q <= bp_mode_e'(wdata_i[1:0]);
      else                       match_q <= wdata_i;
    end
  end

  assign mode_o  = mode_q;
  assign match_o = match_q;
endmodule

// File: rtl/trace_bp_match.sv
module trace_bp_match
  import trace_bp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int EXC_W   = 5,
  parameter int MATCH_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  bp_mode_e           mode_i,
  input  logic [MATCH_W-1:0] match_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [EXC_W-1:0]   exc_i,
  input  logic               accept_i,
  output logic               hit_o,
  output logic               fwd_o
);
  logic skip_q;
  logic pc_eq, exc_eq;

  generate
    if (MATCH_W > ADDR_W) begin : g_pc_wide
      assign pc_eq = (match_i[MATCH_W-1:ADDR_W] == '0) && (pc_i == match_i[ADDR_W-1:0]);
    end else begin : g_pc_exact
      assign pc_eq = (pc_i == match_i[ADDR_W-1:0]);
    end
  endgenerate

  assign exc_eq = (exc_i == match_i[EXC_W-1:0]);

  always_comb begin
    hit_o = 1'b0;
    unique case (mode_i)
      BP_ADDR: hit_o = pc_eq  && !skip_q;
      BP_EXC:  hit_o = exc_eq && !skip_q;
      default: hit_o = 1'b0;
    endcase
  end

  assign fwd_o = (mode_i == BP_PASS) || hit_o;

  // the packet following a hit is exempt from matching
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       skip_q <= 1'b0;
    else if (accept_i) skip_q <= hit_o;
  end
endmodule

// File: rtl/trace_bp_outreg.sv
module trace_bp_outreg #(
  parameter int W = 69
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         space_o,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic         valid_q;
  logic [W-1:0] data_q;

  assign space_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i && space_o) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/trace_bp_filter.sv
module trace_bp_filter
  import trace_bp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int EXC_W   = 5,
  parameter int RES_W   = 32,
  parameter int MATCH_W = (ADDR_W > EXC_W) ? ADDR_W : EXC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [ADDR_W-1:0]  in_pc_i,
  input  logic [EXC_W-1:0]   in_exc_i,
  input  logic [RES_W-1:0]   in_res_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [ADDR_W-1:0]  out_pc_o,
  output logic [EXC_W-1:0]   out_exc_o,
  output logic [RES_W-1:0]   out_res_o,
  input  logic               paused_i,
  input  logic               cfg_we_i,
  input  logic               cfg_sel_i,
  input  logic [MATCH_W-1:0] cfg_wdata_i,
  output logic               pause_req_o
);
  localparam int PKT_W = ADDR_W + EXC_W + RES_W;

  bp_mode_e           cfg_mode;
  logic [MATCH_W-1:0] cfg_match;
  logic               space, accept, hit, fwd;
  logic [PKT_W-1:0]   pkt_in, pkt_out;

  trace_bp_cfg #(.MATCH_W(MATCH_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .paused_i (paused_i),
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .wdata_i  (cfg_wdata_i),
    .mode_o   (cfg_mode),
    .match_o  (cfg_match)
  );

  assign accept = in_valid_i && space;

  trace_bp_match #(.ADDR_W(ADDR_W), .EXC_W(EXC_W), .MATCH_W(MATCH_W)) u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (cfg_mode),
    .match_i  (cfg_match),
    .pc_i     (in_pc_i),
    .exc_i    (in_exc_i),
    .accept_i (accept),
    .hit_o    (hit),
    .fwd_o    (fwd)
  );

  assign pkt_in = {in_pc_i, in_exc_i, in_res_i};

  trace_bp_outreg #(.W(PKT_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept && fwd),
    .data_i  (pkt_in),
    .ready_i (out_ready_i),
    .space_o (space),
    .valid_o (out_valid_o),
    .data_o  (pkt_out)
  );

  assign {out_pc_o, out_exc_o, out_res_o} = pkt_out;
  assign in_ready_o  = space;
  assign pause_req_o = accept && hit;
endmodule

// File: rtl/trace_bp_filter_chk.sv
module trace_bp_filter_chk #(
  parameter int ADDR_W  = 32,
  parameter int EXC_W   = 5,
  parameter int RES_W   = 32,
  parameter int MATCH_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic               in_ready_o,
  input logic [ADDR_W-1:0]  in_pc_i,
  input logic               out_valid_o,
  input logic               out_ready_i,
  input logic [ADDR_W-1:0]  out_pc_o,
  input logic [EXC_W-1:0]   out_exc_o,
  input logic [RES_W-1:0]   out_res_o,
  input logic               paused_i,
  input logic               pause_req_o,
  input logic [1:0]         mode_q,
  input logic [MATCH_W-1:0] match_q
);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_pc_o) &&
                                      $stable(out_exc_o) && $stable(out_res_o)));

  assert_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  assert_pause_on_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o |-> (in_valid_i && in_ready_o));

  assert_pause_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o |=> !pause_req_o);

  assert_pause_fwd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o |=> (out_valid_o && out_pc_o == $past(in_pc_i)));

  assert_cfg_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !paused_i |=> ($stable(mode_q) && $stable(match_q)));

  assert_drop_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd0) |-> !pause_req_o);

  assert_pass_fwd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd1 && in_valid_i && in_ready_o) |=>
      (out_valid_o && out_pc_o == $past(in_pc_i) && !$past(pause_req_o)));
endmodule

bind trace_bp_filter trace_bp_filter_chk #(
  .ADDR_W(ADDR_W), .EXC_W(EXC_W), .RES_W(RES_W), .MATCH_W(MATCH_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_pc_i     (in_pc_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_pc_o    (out_pc_o),
  .out_exc_o   (out_exc_o),
  .out_res_o   (out_res_o),
  .paused_i    (paused_i),
  .pause_req_o (pause_req_o),
  .mode_q      (cfg_mode),
  .match_q     (cfg_match)
);

// File: tb/trace_bp_filter_test.sv
module trace_bp_filter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_pc_i = '0;
  logic [4:0]  in_exc_i = '0;
  logic [31:0] in_res_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_pc_o;
  logic [4:0]  out_exc_o;
  logic [31:0] out_res_o;
  logic        paused_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic        cfg_sel_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        pause_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic [1:0]  m_mode = 2'd1;
  logic [31:0] m_match = '0;
  logic        m_skip = 1'b0;
  logic        m_ov = 1'b0;
  logic [31:0] m_pc = '0;
  logic [4:0]  m_exc = '0;
  logic [31:0] m_res = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_bp_filter uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_pc_i(in_pc_i), .in_exc_i(in_exc_i), .in_res_i(in_res_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_pc_o(out_pc_o), .out_exc_o(out_exc_o), .out_res_o(out_res_o),
    .paused_i(paused_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .pause_req_o(pause_req_o)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic ref_hit(input logic [31:0] pc, input logic [4:0] exc);
    if (m_skip) return 1'b0;
    if (m_mode == 2'd2) return pc == m_match;
    if (m_mode == 2'd3) return exc == m_match[4:0];
    return 1'b0;
  endfunction

  task automatic step(input string tag, input logic v, input logic [31:0] pc, input logic [4:0] exc,
                      input logic [31:0] res, input logic ordy, input logic psd,
                      input logic we, input logic sel, input logic [31:0] wd);
    logic acc, hit, fwd, erdy;
    @(negedge clk);
    in_valid_i = v; in_pc_i = pc; in_exc_i = exc; in_res_i = res;
    out_ready_i = ordy; paused_i = psd; cfg_we_i = we; cfg_sel_i = sel; cfg_wdata_i = wd;
    #1;
    erdy = !m_ov || ordy;
    acc  = v && erdy;
    hit  = ref_hit(pc, exc);
    fwd  = (m_mode == 2'd1) || hit;
    chk(tag, "out_valid", {63'd0, out_valid_o}, {63'd0, m_ov});
    if (m_ov) begin
      chk(tag, "out_pc",  {32'd0, out_pc_o},  {32'd0, m_pc});
      chk(tag, "out_exc", {59'd0, out_exc_o}, {59'd0, m_exc});
      chk(tag, "out_res", {32'd0, out_res_o}, {32'd0, m_res});
    end
    chk(tag, "in_ready", {63'd0, in_ready_o}, {63'd0, erdy});
    chk(tag, "pause_req", {63'd0, pause_req_o}, {63'd0, acc && hit});
    @(posedge clk);
    if (acc) m_skip = hit;
    if (acc && fwd) begin
      m_ov = 1'b1; m_pc = pc; m_exc = exc; m_res = res;
    end else if (ordy) begin
      m_ov = 1'b0;
    end
    if (we && psd) begin
      if (sel) m_match = wd;
      else     m_mode  = wd[1:0];
    end
  endtask

  task automatic pkt(input string tag, input logic [31:0] pc, input logic [4:0] exc, input logic ordy);
    step(tag, 1'b1, pc, exc, $urandom, ordy, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic wr(input string tag, input logic sel, input logic [31:0] wd, input logic psd);
    step(tag, 1'b0, '0, '0, '0, 1'b1, psd, 1'b1, sel, wd);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1", "out_valid", {63'd0, out_valid_o}, 64'd0);
    chk("R1", "pause_req", {63'd0, pause_req_o}, 64'd0);
    chk("R1", "in_ready", {63'd0, in_ready_o}, 64'd1);
    // R1 default pass mode, R3 / R10 forwarding in order
    pkt("R1", 32'h10, 5'd0, 1'b1);
    pkt("R3", 32'h14, 5'd2, 1'b1);
    pkt("R10", 32'h18, 5'd0, 1'b1);
    idle("R10");
    // R9 backpressure
    pkt("R9", 32'h20, 5'd1, 1'b0);
    pkt("R9", 32'h24, 5'd1, 1'b0);
    pkt("R9", 32'h24, 5'd1, 1'b0);
    pkt("R9", 32'h24, 5'd1, 1'b1);
    idle("R9");
    // R8 write while running has no effect
    wr("R8", 1'b0, 32'd0, 1'b0);
    pkt("R8", 32'h30, 5'd0, 1'b1);
    idle("R8");
    // R2 drop mode
    wr("R2", 1'b0, 32'd0, 1'b1);
    pkt("R2", 32'h34, 5'd0, 1'b1);
    pkt("R2", 32'h38, 5'd3, 1'b1);
    idle("R2");
    // R4 address breakpoint, R7 re-match exemption, R6 pulse
    wr("R4", 1'b1, 32'h100, 1'b1);
    wr("R8", 1'b1, 32'h200, 1'b0);
    wr("R4", 1'b0, 32'd2, 1'b1);
    pkt("R4", 32'h0fc, 5'd0, 1'b1);
    pkt("R4", 32'h104, 5'd0, 1'b1);
    pkt("R6", 32'h100, 5'd0, 1'b0);
    pkt("R7", 32'h100, 5'd0, 1'b0);
    pkt("R7", 32'h100, 5'd0, 1'b1);
    pkt("R7", 32'h100, 5'd0, 1'b1);
    pkt("R7", 32'h100, 5'd0, 1'b1);
    idle("R6");
    // R5 exception breakpoint
    wr("R5", 1'b1, 32'hffff_ffe8, 1'b1);
    wr("R5", 1'b0, 32'd3, 1'b1);
    pkt("R5", 32'h1e8, 5'd3, 1'b1);
    pkt("R5", 32'h1ec, 5'd8, 1'b1);
    pkt("R7", 32'h1f0, 5'd8, 1'b1);
    pkt("R5", 32'h1f4, 5'd8, 1'b1);
    idle("R5");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic v, ordy, psd, we, sel;
      logic [31:0] pc, wd;
      logic [4:0] exc;
      v    = ($urandom % 4) != 0;
      ordy = ($urandom % 3) != 0;
      psd  = ($urandom % 5) == 0;
      we   = ($urandom % 8) == 0;
      sel  = $urandom % 2;
      pc   = 32'h40 + 32'(($urandom % 3) * 4);
      exc  = 5'($urandom % 3);
      wd   = sel ? ((($urandom % 2) == 0) ? 32'h40 + 32'(($urandom % 3) * 4) : 32'($urandom % 3))
                 : 32'($urandom % 4);
      step("R10", v, pc, exc, $urandom, ordy, psd, we, sel, wd);
    end
    idle("R10");
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule